// File: doc/BRIEF.md
# Converter result readout interface

This block holds the most recent 16-bit conversion result and lets a host read it over one set of data pins, either as a parallel word or as a serial bit stream. A mode input selects the transfer style. Active-low chip select and active-low read combine into one output enable. When that enable is off the pins float, and the value on the internal bus is forced to zero.

In parallel mode a lane-swap input exchanges the two byte lanes, so an 8-bit host can fetch the word in two reads. An output-coding input selects how the stored offset-binary result is shown, either as it is or as two's complement. In serial mode the host supplies clock pulses, and the word leaves MSB first on bit 0 of the bus, one bit for each pulse. The converter model loads the result register with a one-cycle result-valid strobe. Between strobes the register holds its value, so a read taken while a conversion is running returns the earlier result.

The host clock input is sampled by the system clock. It must stay high and low for at least one system clock period each.

Top module: `adc_readout_if`

## Requirements
- R1: `data_oe` is 1 exactly when `cs_n` and `rd_n` are both 0, in both modes. While `data_oe` is 0, `data_out` is all zeros.
- R2: After reset the stored result is 0x0000. A parallel read then returns 0x0000 with offset coding and 0x8000 with two's complement coding.
- R3: The stored result changes only on a clock edge where `res_valid` is 1. It is visible from the next cycle. Changes on `res_data` without the strobe have no effect on the output.
- R4: Parallel mode (`ser_sel`=0) with `lane_swap`=0 drives the coded result low byte on `data_out[7:0]` and the high byte on `data_out[15:8]`.
- R5: Parallel mode with `lane_swap`=1 drives the coded low byte on `data_out[15:8]` and the coded high byte on `data_out[7:0]`.
- R6: With `fmt_twos`=0 the coded result equals the stored offset-binary value. With `fmt_twos`=1 it is the stored value with bit 15 inverted. Coding is applied before lane steering.
- R7: Serial mode (`ser_sel`=1): after n detected rising edges of `sclk` (n < 16) since `cs_n` went low, `data_out[0]` is bit 15-n of the coded result and `data_out[15:1]` are 0. A rising edge of `sclk` counts from the first system clock edge at which `sclk` is seen high.
- R8: After 16 rising edges of `sclk`, further pulses leave `data_out[0]` at 0.
- R9: Whenever `cs_n` is 1 the serial position returns to the start, so the next selection begins again at bit 15.
- R10: In serial mode the serial bit holds while `sclk` falls and stays low. It changes only after a detected rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | One-cycle strobe that loads a new result |
| res_data | input | 16 | Offset-binary result from the converter |
| ser_sel | input | 1 | 0 selects parallel mode, 1 selects serial mode |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| lane_swap | input | 1 | 1 exchanges the two byte lanes in parallel mode |
| fmt_twos | input | 1 | 1 selects two's complement output, 0 selects offset binary |
| sclk | input | 1 | Host serial clock |
| data_out | output | 16 | Value driven on the data pins |
| data_oe | output | 1 | Output enable for the data pins |

## Verification
A stored result that is wrong shows up on the first enabled parallel read, in any lane and coding combination, one cycle after the strobe that should have loaded it. A serial position counter that is off, fails to saturate, or does not clear on deselect puts a wrong bit on `data_out[0]` at the first pulse where it differs. Checking the bit both after each rising edge and after each falling edge of `sclk` exposes a counter that advances on the wrong edge within one pulse.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;
    localparam int RES_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic {
        CODE_OFFSET = 1'b0,
        CODE_TWOS   = 1'b1
    } out_code_e;

    typedef enum logic {
        MODE_PARALLEL = 1'b0,
        MODE_SERIAL   = 1'b1
    } bus_mode_e;
endpackage

// File: rtl/rd_result_reg.sv
`timescale 1ns/1ps
module rd_result_reg
    import adc_rd_pkg::*;
#(
    parameter int DATA_W = RES_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  out_code_e         code,
    output logic [DATA_W-1:0] word_out
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
    } res_state_t;

    res_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d.word = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // offset binary to two's complement: flip the sign position
    always_comb begin
        word_out = state_q.word;
        if (code == CODE_TWOS) begin
            word_out[DATA_W-1] = ~state_q.word[DATA_W-1];
        end
    end
endmodule

// File: rtl/rd_lane_steer.sv
`timescale 1ns/1ps
module rd_lane_steer
    import adc_rd_pkg::*;
#(
    parameter int DATA_W = RES_W,
    parameter int LANE_W = BYTE_W
) (
    input  logic              swap,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int NUM_LANES = DATA_W / LANE_W;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        localparam int SRC = NUM_LANES - 1 - i;
        assign dout[i*LANE_W +: LANE_W] = swap ? din[SRC*LANE_W +: LANE_W]
                                               : din[i*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/rd_serial_shift.sv
`timescale 1ns/1ps
module rd_serial_shift
    import adc_rd_pkg::*;
#(
    parameter int DATA_W = RES_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sclk,
    input  logic [DATA_W-1:0] word,
    output logic              sbit
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sclk_q;
    } ser_state_t;

    ser_state_t state_d, state_q;
    logic       sclk_rise;
    logic [DATA_W-1:0] shifted;

    assign sclk_rise = sclk && !state_q.sclk_q;

    always_comb begin
        state_d        = state_q;
        state_d.sclk_q = sclk;
        if (!enable) begin
            state_d.cnt = '0;
        end else if (sclk_rise && (state_q.cnt < LAST)) begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // shifting past the last bit leaves zeros at the top
    always_comb begin
        shifted = word << state_q.cnt;
        sbit    = shifted[DATA_W-1];
    end
endmodule

// File: rtl/adc_readout_if.sv
`timescale 1ns/1ps
module adc_readout_if
    import adc_rd_pkg::*;
#(
    parameter int DATA_W = RES_W,
    parameter int LANE_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic              ser_sel,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              lane_swap,
    input  logic              fmt_twos,
    input  logic              sclk,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);
    out_code_e         code;
    bus_mode_e         mode;
    logic [DATA_W-1:0] coded_word;
    logic [DATA_W-1:0] par_word;
    logic              ser_bit;
    logic              ser_en;

    assign code   = fmt_twos ? CODE_TWOS : CODE_OFFSET;
    assign mode   = ser_sel ? MODE_SERIAL : MODE_PARALLEL;
    assign ser_en = (mode == MODE_SERIAL) && !cs_n;

    rd_result_reg #(.DATA_W(DATA_W)) u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (res_valid),
        .din      (res_data),
        .code     (code),
        .word_out (coded_word)
    );

    rd_lane_steer #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_steer (
        .swap (lane_swap),
        .din  (coded_word),
        .dout (par_word)
    );

    rd_serial_shift #(.DATA_W(DATA_W)) u_serial (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (ser_en),
        .sclk   (sclk),
        .word   (coded_word),
        .sbit   (ser_bit)
    );

    always_comb begin
        data_oe  = !(cs_n || rd_n);
        data_out = '0;
        if (data_oe) begin
            case (mode)
                MODE_PARALLEL: data_out = par_word;
                MODE_SERIAL:   data_out[0] = ser_bit;
                default:       data_out = '0;
            endcase
        end
    end
endmodule

// File: rtl/adc_readout_if_chk.sv
`timescale 1ns/1ps
module adc_readout_if_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic              ser_sel,
    input logic              cs_n,
    input logic              rd_n,
    input logic              lane_swap,
    input logic              fmt_twos,
    input logic              sclk,
    input logic [DATA_W-1:0] data_out,
    input logic              data_oe
);
    localparam int PC_W = $clog2(DATA_W + 1);

    logic            sclk_prev;
    logic [PC_W-1:0] pulses_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            pulses_q  <= '0;
        end else begin
            sclk_prev <= sclk;
            if (!(ser_sel && !cs_n)) begin
                pulses_q <= '0;
            end else if (sclk && !sclk_prev && (pulses_q < PC_W'(DATA_W))) begin
                pulses_q <= pulses_q + 1'b1;
            end
        end
    end

    // R1
    float_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (data_out == '0 && !data_oe));

    // R3
    hold_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(res_valid) && !ser_sel && data_oe && $past(!ser_sel && data_oe)
         && $stable(lane_swap) && $stable(fmt_twos)) |-> $stable(data_out));

    // R3
    load_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(res_valid) && !ser_sel && data_oe && !lane_swap && !fmt_twos)
        |-> (data_out == $past(res_data)));

    // R7
    serial_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_sel |-> (data_out[DATA_W-1:1] == '0));

    // R8
    serial_exhausted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_sel && data_oe && pulses_q == PC_W'(DATA_W)) |-> !data_out[0]);

    // R10
    serial_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_sel && data_oe && $past(ser_sel && data_oe) && $stable(fmt_twos)
         && !$past(res_valid) && !($past(sclk) && !$past(sclk, 2)))
        |-> $stable(data_out[0]));
endmodule

bind adc_readout_if adc_readout_if_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .res_data  (res_data),
    .ser_sel   (ser_sel),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .lane_swap (lane_swap),
    .fmt_twos  (fmt_twos),
    .sclk      (sclk),
    .data_out  (data_out),
    .data_oe   (data_oe)
);

// File: tb/adc_readout_if_test.sv
`timescale 1ns/1ps
module adc_readout_if_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic        ser_sel = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        lane_swap = 1'b0;
    logic        fmt_twos = 1'b0;
    logic        sclk = 1'b0;
    logic [15:0] data_out;
    logic        data_oe;

    int n_run  = 0;
    int n_fail = 0;
    logic [15:0] exp_word = '0;

    always #2.5 clk = ~clk;

    adc_readout_if uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .ser_sel(ser_sel), .cs_n(cs_n), .rd_n(rd_n), .lane_swap(lane_swap),
        .fmt_twos(fmt_twos), .sclk(sclk), .data_out(data_out), .data_oe(data_oe)
    );

    function automatic logic [15:0] f_coded(logic [15:0] w, logic twos);
        return twos ? (w ^ 16'h8000) : w;
    endfunction

    function automatic logic [15:0] f_par(logic [15:0] w, logic twos, logic swp);
        logic [15:0] c = f_coded(w, twos);
        return swp ? {c[7:0], c[15:8]} : c;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic convert(logic [15:0] v);
        res_valid = 1'b1;
        res_data  = v;
        tick();
        res_valid = 1'b0;
        res_data  = 16'($urandom);
        exp_word  = v;
    endtask

    task automatic check_par(string req);
        logic oe = !cs_n && !rd_n;
        chk({req, " oe"}, 32'(data_oe), 32'(oe));
        chk({req, " data"}, 32'(data_out), oe ? 32'(f_par(exp_word, fmt_twos, lane_swap)) : 32'h0);
    endtask

    task automatic check_ser(string req, int n);
        logic [15:0] c = f_coded(exp_word, fmt_twos);
        logic b = (n < 16) ? c[15 - n] : 1'b0;
        chk({req, " bus"}, 32'(data_out), 32'(b));
    endtask

    task automatic serial_word(logic [15:0] v, int extra);
        convert(v);
        ser_sel = 1'b1; rd_n = 1'b0; cs_n = 1'b0;
        #1;
        check_ser("R7 start", 0);
        for (int n = 1; n <= 16 + extra; n++) begin
            sclk = 1'b1;
            tick();
            check_ser((n > 16) ? "R8" : "R7", n);
            sclk = 1'b0;
            tick();
            check_ser("R10 hold", n);
        end
        cs_n = 1'b1;
        tick();
        chk("R1 serial deselect", 32'({data_oe, data_out}), 32'h0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R2 reset value, both codings
        chk("R2 idle oe", 32'(data_oe), 32'h0);
        cs_n = 1'b0; rd_n = 1'b0; #1;
        chk("R2 offset", 32'(data_out), 32'h0000);
        fmt_twos = 1'b1; #1;
        chk("R2 twos", 32'(data_out), 32'h8000);
        fmt_twos = 1'b0;

        // R4 R5 R6 directed
        convert(16'h12F4);
        check_par("R4");
        lane_swap = 1'b1; #1; check_par("R5");
        fmt_twos = 1'b1; #1; check_par("R6 swapped");
        chk("R6 exact", 32'(data_out), 32'h F492);
        lane_swap = 1'b0; #1;
        chk("R6 unswapped", 32'(data_out), 32'h 92F4);
        fmt_twos = 1'b0;

        // R3 read during conversion: data bus noise without strobe
        for (int i = 0; i < 8; i++) begin
            res_data = 16'($urandom);
            tick();
            check_par("R3 no strobe");
        end

        // R1 R3 R4 R5 R6 random
        for (int i = 0; i < 300; i++) begin
            cs_n      = 1'($urandom);
            rd_n      = 1'($urandom);
            lane_swap = 1'($urandom);
            fmt_twos  = 1'($urandom);
            if (($urandom % 4) == 0) convert(16'($urandom));
            else begin
                res_data = 16'($urandom);
                tick();
            end
            check_par("R1 R3 R4 R5 R6 random");
        end

        // R1 serial with read high floats
        ser_sel = 1'b1; cs_n = 1'b0; rd_n = 1'b1; #1;
        chk("R1 serial rd high", 32'({data_oe, data_out}), 32'h0);
        cs_n = 1'b1;
        tick();

        // R7 R8 R10 serial directed and random
        fmt_twos = 1'b0;
        serial_word(16'hA5C3, 3);
        fmt_twos = 1'b1;
        serial_word(16'h0001, 2);
        for (int i = 0; i < 6; i++) begin
            fmt_twos = 1'($urandom);
            serial_word(16'($urandom), i % 3);
        end

        // R9 restart after partial transfer
        fmt_twos = 1'b0;
        convert(16'h4000);
        cs_n = 1'b0; rd_n = 1'b0;
        for (int n = 1; n <= 5; n++) begin
            sclk = 1'b1; tick(); sclk = 1'b0; tick();
        end
        check_ser("R9 mid", 5);
        cs_n = 1'b1; tick();
        cs_n = 1'b0; #1;
        check_ser("R9 restart", 0);
        sclk = 1'b1; tick(); sclk = 1'b0;
        check_ser("R9 second bit", 1);
        cs_n = 1'b1; ser_sel = 1'b0;
        tick();

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule